// File: doc/BRIEF.md
# Write-Leveling Training Controller

This block sequences one hardware-assisted write-leveling pass for a single memory module with eight byte lanes. On a start pulse it latches the target module, the module type, an optional per-lane seed override and a pass selector. It then takes the memory channel out of normal housekeeping by stopping auto refresh and zeroing the short ZQ calibration interval. It asks an external mode-register sequencer to put the ranks into leveling mode and waits for the ranks to settle. Next it enables leveling ODT, writes a seed delay into each lane of the phy and holds the training enable for a fixed window.

After the window it reads every lane's measured delay back. A result that wrapped around is corrected, and the value is written out as that lane's write DQS delay. The controller then drops ODT, asks the sequencer to return the ranks to normal operation, restores refresh and ZQ calibration, and signals done. The phy measurement is outside the block: it arrives on a combinational read port indexed by the controller.

Every delay is 8 bits wide. Bits 7:5 hold the gross part and bits 4:0 hold the fine part.

Top module: `wlvl_train`

## Requirements
- R1: Out of reset and while idle, `busy`, `refreshOff`, `odtEn`, `trainEn`, `seqReq`, `laneWrEn` and `dqsWrEn` are 0 and `zqInterval` is 2.
- R2: In the cycle after `start` is sampled in idle, `busy` and `refreshOff` are 1, `zqInterval` is 0 and `targetDimm` equals the `dimmSel` value sampled with `start`. `busy` stays high up to and including the `done` cycle.
- R3: The enter request (`seqReq`=1, `seqMode`=1) is held until `seqAck`. After the acknowledge cycle the block waits exactly 40 cycles, and `odtEn` rises in the 41st cycle.
- R4: `odtEn` stays high for exactly 10 cycles before the first seed write. It remains high through seeding, training and collection.
- R5: Seeds are written one lane per cycle with `laneWrEn`, lanes 0 to 7 in ascending order. The default seed depends on `dimmKind`: 1 (registered) gives 0x41, 2 (small outline) gives 0x12, and 0 or 3 give 0x1A.
- R6: When `ovrEn` is 1 at start, lane i receives `ovrSeeds[8*i+7:8*i]` instead of the default.
- R7: `trainEn` is high for exactly 200 consecutive cycles, or 32 when `secondPass` was 1 at start. It is high only while `odtEn` and `refreshOff` are high.
- R8: Results are collected one lane per cycle in ascending order, with `laneRdIdx` equal to `dqsWrIdx` while `dqsWrEn` is 1. The written delay is 0 when the lane's seed has gross 0 and the measurement has gross 3. Otherwise it is the measurement unchanged.
- R9: After collection `odtEn` falls. Exactly 10 cycles later the exit request (`seqReq`=1, `seqMode`=0) rises and is held until `seqAck`.
- R10: In the cycle after the exit acknowledge, `done` is high for one cycle with `refreshOff`=0 and `zqInterval`=2. `busy` is 0 in the following cycle.
- R11: `start` is ignored while `busy`. Changes to the configuration inputs during a pass do not affect that pass, and no second pass begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a leveling pass (idle only) |
| dimmSel | input | 2 | Module to train |
| dimmKind | input | 2 | Module type: 0 unbuffered, 1 registered, 2 small outline |
| ovrEn | input | 1 | Use per-lane override seeds |
| ovrSeeds | input | 64 | Override seeds, lane i in bits 8i+7:8i |
| secondPass | input | 1 | Use the short training window |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle completion pulse |
| targetDimm | output | 2 | Latched module under training |
| refreshOff | output | 1 | Auto refresh disabled |
| zqInterval | output | 2 | Short ZQ calibration interval code |
| seqReq | output | 1 | Mode-register sequencer request |
| seqMode | output | 1 | 1 enter leveling, 0 return to normal |
| seqAck | input | 1 | Sequencer acknowledge |
| odtEn | output | 1 | Leveling ODT enable |
| trainEn | output | 1 | Phy training enable |
| laneWrEn | output | 1 | Seed write strobe |
| laneWrIdx | output | 3 | Lane receiving the seed |
| laneWrDly | output | 8 | Seed value |
| laneRdIdx | output | 3 | Lane whose measurement is read |
| laneRdDly | input | 8 | Measured delay of lane laneRdIdx |
| dqsWrEn | output | 1 | Write DQS delay store strobe |
| dqsWrIdx | output | 3 | Lane of the stored delay |
| dqsWrDly | output | 8 | Corrected delay |

## Verification
A corrupted state register or counter shows up at the ports as a window of the wrong length. The 40-cycle settle, either 10-cycle ODT gap or the training window would be off, and the bench measures each of these against the acknowledge and ODT edges within the same pass. A wrong seed register or correction term appears on the very lane that carries it, in the one cycle that lane is written or collected. A lost or doubled handshake shows as a missing or extra done pulse, or as busy still high on the cycle after done.

// File: rtl/wlvl_pkg.sv
package wlvl_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_REF_OFF, ST_MR_ENTER, ST_WAIT_MR, ST_ODT_ON,
    ST_SEED, ST_TRAIN, ST_COLLECT, ST_ODT_OFF, ST_MR_EXIT, ST_FINISH
  } wlState_e;

  // which limit the shared counter is compared against
  typedef enum logic [1:0] {
    WAIT_MR, WAIT_ODT, WAIT_TRAIN, WAIT_LANES
  } waitSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     capture;
    logic     cntRun;
    waitSel_e waitSel;
  } wlStrobe_t;

endpackage

// File: rtl/wlvl_ctl.sv
module wlvl_ctl
  import wlvl_pkg::*;
#(
  parameter int ZQ_W      = 2,
  parameter int ZQ_NORMAL = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic            seqAck,
  input  logic            cntHit,
  output wlStrobe_t       stb,
  output logic            busy,
  output logic            done,
  output logic            refreshOff,
  output logic [ZQ_W-1:0] zqInterval,
  output logic            seqReq,
  output logic            seqMode,
  output logic            odtEn,
  output logic            trainEn,
  output logic            laneWrEn,
  output logic            dqsWrEn
);

  wlState_e state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt         = state;
    stb.capture = 1'b0;
    stb.cntRun  = 1'b0;
    stb.waitSel = WAIT_MR;
    seqReq      = 1'b0;
    seqMode     = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          nxt         = ST_REF_OFF;
          stb.capture = 1'b1;
        end
      end
      ST_REF_OFF: nxt = ST_MR_ENTER;
      ST_MR_ENTER: begin
        seqReq  = 1'b1;
        seqMode = 1'b1;
        if (seqAck) nxt = ST_WAIT_MR;
      end
      ST_WAIT_MR: begin
        stb.waitSel = WAIT_MR;
        stb.cntRun  = !cntHit;
        if (cntHit) nxt = ST_ODT_ON;
      end
      ST_ODT_ON: begin
        stb.waitSel = WAIT_ODT;
        stb.cntRun  = !cntHit;
        if (cntHit) nxt = ST_SEED;
      end
      ST_SEED: begin
        stb.waitSel = WAIT_LANES;
        stb.cntRun  = !cntHit;
        if (cntHit) nxt = ST_TRAIN;
      end
      ST_TRAIN: begin
        stb.waitSel = WAIT_TRAIN;
        stb.cntRun  = !cntHit;
        if (cntHit) nxt = ST_COLLECT;
      end
      ST_COLLECT: begin
        stb.waitSel = WAIT_LANES;
        stb.cntRun  = !cntHit;
        if (cntHit) nxt = ST_ODT_OFF;
      end
      ST_ODT_OFF: begin
        stb.waitSel = WAIT_ODT;
        stb.cntRun  = !cntHit;
        if (cntHit) nxt = ST_MR_EXIT;
      end
      ST_MR_EXIT: begin
        seqReq = 1'b1;
        if (seqAck) nxt = ST_FINISH;
      end
      ST_FINISH: nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  assign busy       = (state != ST_IDLE);
  assign done       = (state == ST_FINISH);
  assign refreshOff = busy && !done;
  assign zqInterval = refreshOff ? '0 : ZQ_W'(ZQ_NORMAL);
  assign odtEn      = (state == ST_ODT_ON) || (state == ST_SEED) ||
                      (state == ST_TRAIN)  || (state == ST_COLLECT);
  assign trainEn    = (state == ST_TRAIN);
  assign laneWrEn   = (state == ST_SEED);
  assign dqsWrEn    = (state == ST_COLLECT);

endmodule

// File: rtl/wlvl_dp.sv
module wlvl_dp
  import wlvl_pkg::*;
#(
  parameter int LANES       = 8,
  parameter int DLY_W       = 8,
  parameter int GROSS_W     = 3,
  parameter int DIMM_W      = 2,
  parameter int MR_WAIT     = 40,
  parameter int ODT_WAIT    = 10,
  parameter int TRAIN_LONG  = 200,
  parameter int TRAIN_SHORT = 32,
  parameter int WRAP_GROSS  = 3,
  parameter logic [DLY_W-1:0] SEED_REG   = 8'h41,
  parameter logic [DLY_W-1:0] SEED_SO    = 8'h12,
  parameter logic [DLY_W-1:0] SEED_UNBUF = 8'h1A,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  wlStrobe_t              stb,
  input  logic [DIMM_W-1:0]      dimmSel,
  input  logic [1:0]             dimmKind,
  input  logic                   ovrEn,
  input  logic [LANES*DLY_W-1:0] ovrSeeds,
  input  logic                   secondPass,
  input  logic [DLY_W-1:0]       laneRdDly,
  output logic                   cntHit,
  output logic [DIMM_W-1:0]      targetDimm,
  output logic [LANE_W-1:0]      laneIdx,
  output logic [DLY_W-1:0]       seedDly,
  output logic [DLY_W-1:0]       resultDly
);

  localparam int MAX_A   = (MR_WAIT > ODT_WAIT) ? MR_WAIT : ODT_WAIT;
  localparam int MAX_B   = (MAX_A > TRAIN_LONG) ? MAX_A : TRAIN_LONG;
  localparam int CNT_MAX = (MAX_B > LANES) ? MAX_B : LANES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic             shortPass;
  logic [DLY_W-1:0] defSeed;
  logic [DLY_W-1:0] seedMem [LANES];

  // shared wait / lane counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cnt <= '0;
    else if (stb.cntRun) cnt <= cnt + 1'b1;
    else                 cnt <= '0;
  end

  always_comb begin
    case (stb.waitSel)
      WAIT_MR:    limit = CNT_W'(MR_WAIT - 1);
      WAIT_ODT:   limit = CNT_W'(ODT_WAIT - 1);
      WAIT_TRAIN: limit = shortPass ? CNT_W'(TRAIN_SHORT - 1) : CNT_W'(TRAIN_LONG - 1);
      default:    limit = CNT_W'(LANES - 1);
    endcase
  end

  assign cntHit  = (cnt == limit);
  assign laneIdx = cnt[LANE_W-1:0];

  // configuration captured with start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      targetDimm <= '0;
      shortPass  <= 1'b0;
    end else if (stb.capture) begin
      targetDimm <= dimmSel;
      shortPass  <= secondPass;
    end
  end

  always_comb begin
    case (dimmKind)
      2'd1:    defSeed = SEED_REG;
      2'd2:    defSeed = SEED_SO;
      default: defSeed = SEED_UNBUF;
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : gSeed
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            seedMem[g] <= '0;
      else if (stb.capture) seedMem[g] <= ovrEn ? ovrSeeds[g*DLY_W +: DLY_W] : defSeed;
    end
  end

  assign seedDly = seedMem[laneIdx];

  // wrap-around correction on the measured delay
  logic [GROSS_W-1:0] seedGross, measGross;
  logic               wrapped;

  assign seedGross = seedDly[DLY_W-1 -: GROSS_W];
  assign measGross = laneRdDly[DLY_W-1 -: GROSS_W];
  assign wrapped   = (seedGross == '0) && (measGross == GROSS_W'(WRAP_GROSS));
  assign resultDly = wrapped ? '0 : laneRdDly;

endmodule

// File: rtl/wlvl_train.sv
module wlvl_train
  import wlvl_pkg::*;
#(
  parameter int LANES       = 8,
  parameter int DLY_W       = 8,
  parameter int GROSS_W     = 3,
  parameter int DIMM_W      = 2,
  parameter int ZQ_W        = 2,
  parameter int ZQ_NORMAL   = 2,
  parameter int MR_WAIT     = 40,
  parameter int ODT_WAIT    = 10,
  parameter int TRAIN_LONG  = 200,
  parameter int TRAIN_SHORT = 32,
  parameter int WRAP_GROSS  = 3,
  parameter logic [DLY_W-1:0] SEED_REG   = 8'h41,
  parameter logic [DLY_W-1:0] SEED_SO    = 8'h12,
  parameter logic [DLY_W-1:0] SEED_UNBUF = 8'h1A,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [DIMM_W-1:0]      dimmSel,
  input  logic [1:0]             dimmKind,
  input  logic                   ovrEn,
  input  logic [LANES*DLY_W-1:0] ovrSeeds,
  input  logic                   secondPass,
  output logic                   busy,
  output logic                   done,
  output logic [DIMM_W-1:0]      targetDimm,
  output logic                   refreshOff,
  output logic [ZQ_W-1:0]        zqInterval,
  output logic                   seqReq,
  output logic                   seqMode,
  input  logic                   seqAck,
  output logic                   odtEn,
  output logic                   trainEn,
  output logic                   laneWrEn,
  output logic [LANE_W-1:0]      laneWrIdx,
  output logic [DLY_W-1:0]       laneWrDly,
  output logic [LANE_W-1:0]      laneRdIdx,
  input  logic [DLY_W-1:0]       laneRdDly,
  output logic                   dqsWrEn,
  output logic [LANE_W-1:0]      dqsWrIdx,
  output logic [DLY_W-1:0]       dqsWrDly
);

  wlStrobe_t          stb;
  logic               cntHit;
  logic [LANE_W-1:0]  laneIdx;

  wlvl_ctl #(.ZQ_W(ZQ_W), .ZQ_NORMAL(ZQ_NORMAL)) u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .seqAck(seqAck), .cntHit(cntHit),
    .stb(stb), .busy(busy), .done(done), .refreshOff(refreshOff),
    .zqInterval(zqInterval), .seqReq(seqReq), .seqMode(seqMode),
    .odtEn(odtEn), .trainEn(trainEn), .laneWrEn(laneWrEn), .dqsWrEn(dqsWrEn)
  );

  wlvl_dp #(
    .LANES(LANES), .DLY_W(DLY_W), .GROSS_W(GROSS_W), .DIMM_W(DIMM_W),
    .MR_WAIT(MR_WAIT), .ODT_WAIT(ODT_WAIT), .TRAIN_LONG(TRAIN_LONG),
    .TRAIN_SHORT(TRAIN_SHORT), .WRAP_GROSS(WRAP_GROSS),
    .SEED_REG(SEED_REG), .SEED_SO(SEED_SO), .SEED_UNBUF(SEED_UNBUF)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .dimmSel(dimmSel), .dimmKind(dimmKind),
    .ovrEn(ovrEn), .ovrSeeds(ovrSeeds), .secondPass(secondPass),
    .laneRdDly(laneRdDly), .cntHit(cntHit), .targetDimm(targetDimm),
    .laneIdx(laneIdx), .seedDly(laneWrDly), .resultDly(dqsWrDly)
  );

  assign laneWrIdx = laneIdx;
  assign laneRdIdx = laneIdx;
  assign dqsWrIdx  = laneIdx;

endmodule

// File: rtl/wlvl_chk.sv
module wlvl_chk #(
  parameter int LANES      = 8,
  parameter int TRAIN_LONG = 200,
  parameter int DIMM_W     = 2,
  parameter int ZQ_W       = 2,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int RUN_W  = $clog2(TRAIN_LONG + 2)
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic [DIMM_W-1:0] targetDimm,
  input logic              refreshOff,
  input logic [ZQ_W-1:0]   zqInterval,
  input logic              seqReq,
  input logic              seqMode,
  input logic              seqAck,
  input logic              odtEn,
  input logic              trainEn,
  input logic              laneWrEn,
  input logic [LANE_W-1:0] laneWrIdx,
  input logic              dqsWrEn,
  input logic [LANE_W-1:0] dqsWrIdx
);

  logic [RUN_W-1:0] trRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        trRun <= '0;
    else if (trainEn) trRun <= trRun + 1'b1;
    else              trRun <= '0;
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !odtEn && !trainEn && !seqReq && !laneWrEn && !dqsWrEn && !refreshOff);

  // R2
  refresh_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    refreshOff |-> busy && (zqInterval == '0));

  // R11
  target_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && !done |=> $stable(targetDimm));

  // R3
  seq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqReq && !seqAck |=> seqReq && $stable(seqMode));

  // R5
  seed_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    laneWrEn && $past(laneWrEn) |-> laneWrIdx == LANE_W'($past(laneWrIdx) + 1'b1));

  // R8
  collect_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    dqsWrEn && $past(dqsWrEn) |-> dqsWrIdx == LANE_W'($past(dqsWrIdx) + 1'b1));

  // R4
  seed_under_odt_chk: assert property (@(posedge clk) disable iff (!rstN)
    laneWrEn |-> odtEn && !trainEn);

  // R7
  train_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    trainEn |-> odtEn && refreshOff && (trRun < RUN_W'(TRAIN_LONG)));

  // R7
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({laneWrEn, dqsWrEn, trainEn, seqReq}));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy && !done);

endmodule

bind wlvl_train wlvl_chk #(
  .LANES(LANES), .TRAIN_LONG(TRAIN_LONG), .DIMM_W(DIMM_W), .ZQ_W(ZQ_W)
) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .targetDimm(targetDimm),
  .refreshOff(refreshOff), .zqInterval(zqInterval), .seqReq(seqReq),
  .seqMode(seqMode), .seqAck(seqAck), .odtEn(odtEn), .trainEn(trainEn),
  .laneWrEn(laneWrEn), .laneWrIdx(laneWrIdx), .dqsWrEn(dqsWrEn), .dqsWrIdx(dqsWrIdx)
);

// File: tb/tb_wlvl_train.sv
`timescale 1ns/1ps
module tb_wlvl_train;

  localparam int MR_WAIT = 40, ODT_WAIT = 10, ACK_LAT = 3;

  logic clk = 0, rstN = 0, start = 0, ovrEn = 0, secondPass = 0, seqAck = 0;
  logic [1:0] dimmSel = 0, dimmKind = 0;
  logic [63:0] ovrSeeds = '0;
  logic busy, done, refreshOff, seqReq, seqMode, odtEn, trainEn, laneWrEn, dqsWrEn;
  logic [1:0] targetDimm, zqInterval;
  logic [2:0] laneWrIdx, laneRdIdx, dqsWrIdx;
  logic [7:0] laneWrDly, laneRdDly, dqsWrDly;
  logic [7:0] meas [8];

  always #2.5 clk = ~clk;
  assign laneRdDly = meas[laneRdIdx];

  wlvl_train dut (.*);

  int checks = 0, failures = 0, doneCount = 0, expTrain = 0;
  logic [1:0] expDimm = 0;
  logic [10:0] seedQ[$];
  logic [10:0] dqsQ[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] expSeed(input logic [1:0] kind, input bit oe,
                                         input logic [63:0] ov, input int lane);
    if (oe) return ov[lane*8 +: 8];
    case (kind)
      2'd1: return 8'h41;
      2'd2: return 8'h12;
      default: return 8'h1A;
    endcase
  endfunction

  // sequencer model: acknowledge ACK_LAT cycles after a request
  initial begin
    int n = 0;
    forever begin
      @(posedge clk); #1;
      if (seqReq) begin n++; seqAck = (n == ACK_LAT); end
      else begin n = 0; seqAck = 0; end
    end
  end

  // monitor / scoreboard
  initial begin
    int cyc = 0, ackCyc = 0, odtOnCyc = 0, odtOffCyc = 0, trCnt = 0;
    bit pBusy = 0, pOdt = 0, pTr = 0, pReq = 0;
    forever begin
      @(negedge clk);
      if (!rstN) continue;
      cyc++;
      if (busy && !pBusy)  // R2
        chk(refreshOff && zqInterval == 0 && targetDimm == expDimm, "R2",
            "entry refresh/zq/target", {refreshOff, zqInterval, targetDimm}, {1'b1, 2'd0, expDimm});
      if (seqReq && seqAck && seqMode) ackCyc = cyc;
      if (odtEn && !pOdt) begin
        odtOnCyc = cyc;
        chk(cyc - ackCyc == MR_WAIT + 1, "R3", "settle before ODT", cyc - ackCyc, MR_WAIT + 1);
      end
      if (!odtEn && pOdt) odtOffCyc = cyc;
      if (laneWrEn) begin
        logic [10:0] e;
        if (laneWrIdx == 0)
          chk(cyc - odtOnCyc == ODT_WAIT, "R4", "ODT settle before seeds", cyc - odtOnCyc, ODT_WAIT);
        if (seedQ.size() == 0) chk(0, "R5", "unexpected seed write", laneWrIdx, 0);
        else begin
          e = seedQ.pop_front();
          chk({laneWrIdx, laneWrDly} == e, "R5/R6", "seed lane,value", {laneWrIdx, laneWrDly}, e);
        end
      end
      if (trainEn) trCnt++;
      if (!trainEn && pTr) begin
        chk(trCnt == expTrain, "R7", "training window", trCnt, expTrain);
        trCnt = 0;
      end
      if (dqsWrEn) begin
        logic [10:0] e;
        chk(laneRdIdx == dqsWrIdx, "R8", "read index", laneRdIdx, dqsWrIdx);
        if (dqsQ.size() == 0) chk(0, "R8", "unexpected result write", dqsWrIdx, 0);
        else begin
          e = dqsQ.pop_front();
          chk({dqsWrIdx, dqsWrDly} == e, "R8", "result lane,value", {dqsWrIdx, dqsWrDly}, e);
        end
      end
      if (seqReq && !seqMode && !pReq)
        chk(cyc - odtOffCyc == ODT_WAIT, "R9", "ODT off to exit request", cyc - odtOffCyc, ODT_WAIT);
      if (done) begin
        doneCount++;
        chk(!refreshOff && zqInterval == 2, "R10", "restore at done",
            {refreshOff, zqInterval}, {1'b0, 2'd2});
      end
      pBusy = busy; pOdt = odtEn; pTr = trainEn; pReq = seqReq;
    end
  end

  // driver
  task automatic doRun(input logic [1:0] dimm, input logic [1:0] kind, input bit oe,
                       input logic [63:0] ov, input bit sp, input logic [63:0] m,
                       input bit inject);
    int d0 = doneCount;
    for (int i = 0; i < 8; i++) begin
      logic [7:0] s, r;
      meas[i] = m[i*8 +: 8];
      s = expSeed(kind, oe, ov, i);
      r = (s[7:5] == 3'd0 && meas[i][7:5] == 3'd3) ? 8'h00 : meas[i];
      seedQ.push_back({3'(i), s});
      dqsQ.push_back({3'(i), r});
    end
    expTrain = sp ? 32 : 200;
    expDimm = dimm;
    @(posedge clk); #1;
    dimmSel = dimm; dimmKind = kind; ovrEn = oe; ovrSeeds = ov; secondPass = sp; start = 1;
    @(posedge clk); #1;
    start = 0;
    if (inject) begin  // R11: start and new config while busy
      while (!trainEn) begin @(posedge clk); #1; end
      dimmSel = ~dimm; dimmKind = 2'd1; ovrEn = 0; secondPass = ~sp; start = 1;
      @(posedge clk); #1;
      start = 0;
    end
    do @(negedge clk); while (!done);
    @(negedge clk);
    chk(!busy, "R10", "busy after done", busy, 0);
    repeat (3) @(negedge clk);
    chk(!busy && doneCount == d0 + 1, "R11", "single pass, no restart",
        {busy, 8'(doneCount - d0)}, 1);
    chk(seedQ.size() == 0 && dqsQ.size() == 0, "R5/R8", "all lanes seen",
        seedQ.size() + dqsQ.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) meas[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(!busy && !refreshOff && zqInterval == 2 && !odtEn && !trainEn && !seqReq &&
        !laneWrEn && !dqsWrEn, "R1", "reset outputs",
        {busy, refreshOff, zqInterval, odtEn, trainEn, seqReq}, 7'b0010000);
    rstN = 1;
    repeat (2) @(negedge clk);
    chk(!busy && zqInterval == 2, "R1", "idle after reset", {busy, zqInterval}, 2);
    // unbuffered, gross-0 seed: gross-3 results wrap to 0
    doRun(2'd1, 2'd0, 0, 64'h0, 0, 64'h20E0801F407F6065, 0);
    // registered seed 0x41, short window: nothing corrected
    doRun(2'd2, 2'd1, 0, 64'h0, 1, 64'h20E0801F407F6065, 0);
    // override seeds (kind SO ignored), start injected while busy
    doRun(2'd3, 2'd2, 1, 64'h7A1F45003F102505, 0, {8{8'h6C}}, 1);
    // small outline default 0x12
    doRun(2'd0, 2'd2, 0, 64'h0, 1, 64'h7F00655F3F1F6012, 0);
    // kind 3 falls back to 0x1A
    doRun(2'd1, 2'd3, 0, 64'h0, 0, 64'h6060606011223344, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule